// File: doc/BRIEF.md
# PRBS Stream Checker with Slip Discrimination

This block watches a serial bit stream that is meant to carry a maximal-length pseudo-random sequence and marks every received bit that disagrees with the sequence. After reset, and after every resynchronisation, it loads its local sequence register directly from the incoming bits. Once the register is full, it advances the register from its own feedback and compares each new received bit with the predicted bit. A mismatch raises a one-cycle error flag and advances a saturating error counter.

The block does not accept a high error rate alone as evidence of lost alignment. A second predictor of the same form runs on the error stream. When the channel has slipped by one or more bits, the error stream is itself a phase-shifted copy of the sequence, so the second predictor follows it almost perfectly. A random burst does not have this property. The block requests a resync only when a measurement window shows many main errors together with very few slip errors. A burst therefore passes through as counted errors and does not cause a needless reacquisition.

Top module: `prbs_slip_checker`

## Requirements
- R1: While rst_n is low, and on the first cycle after release, err_flag and resync_req are 0 and err_count is 0. A reset in the middle of a run clears a non-zero count.
- R2: After reset and after every resync, the next ORDER (23) valid bits are loaded into the sequence register without any comparison. Any 23-bit non-zero content is accepted. These bits raise no err_flag and are not counted.
- R3: Once loaded, the local sequence runs freely as x[n] = x[n-23] XOR x[n-18]. On the cycle after a valid bit that differs from this prediction, err_flag is 1 for exactly one cycle. An isolated corrupted bit flags that bit only.
- R4: A received stream that follows the recurrence raises no err_flag and leaves err_count at 0.
- R5: Cycles with rx_valid low are ignored. They raise no flag, do not advance the sequence, do not change the count and do not disturb synchronisation, whatever rx_bit carries.
- R6: The error stream feeds a second predictor with the same recurrence. A slip error is e[n] XOR e[n-23] XOR e[n-18]. The history of this predictor is cleared while loading.
- R7: Windows of WIN_LEN (256) valid tracking bits are counted from the end of loading. At the last bit of a window, resync_req pulses for one cycle if that window held at least ERR_HI (64) errors and at most SLIP_LO (8) slip errors. Loading then restarts.
- R8: A burst of inverted bits with no slip raises no resync. Every bit in the burst is flagged and counted, and after the burst a clean stream checks with no errors.
- R9: After a one-bit slip (a deleted bit), the block requests a resync, reloads and then tracks the slipped stream with no further errors.
- R10: err_count rises by one for each flagged bit, never counts during loading, and holds at 2^CNT_W-1 once reached.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Rising-edge clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| rx_bit | input | 1 | Received serial bit |
| rx_valid | input | 1 | rx_bit carries a new bit this cycle |
| err_flag | output | 1 | The bit accepted on the previous cycle mismatched |
| resync_req | output | 1 | One-cycle pulse: slip recognised, reload starting |
| err_count | output | CNT_W | Saturating count of flagged bits |

## Verification
The bench keeps the defaults ORDER=23, taps 23/18, WIN_LEN=256, ERR_HI=64 and SLIP_LO=8, so the windows and thresholds it exercises are the real ones. It sets CNT_W to 8, which lets a 300-bit inverted burst drive the counter into saturation within a short run. A slip is produced by deleting one bit from the reference sequence. The bench then checks that the resync pulse lands on a window boundary counted from the end of loading.

// File: rtl/prbs_chk_pkg.sv
package prbs_chk_pkg;
  typedef enum logic {
    ST_LOAD  = 1'b0,
    ST_TRACK = 1'b1
  } sync_state_e;
endpackage

// File: rtl/prbs_tap_predictor.sv
// History register plus two-tap prediction of the next bit.
module prbs_tap_predictor #(
  parameter int unsigned ORDER = 23,
  parameter int unsigned TAP_A = 23,
  parameter int unsigned TAP_B = 18
) (
  input  logic clk,
  input  logic rst_n,
  input  logic shift_en,
  input  logic clear,
  input  logic shift_bit,
  output logic pred
);
  logic [ORDER-1:0] hist_q;
  logic [ORDER-1:0] hist_d;

  always_comb begin
    hist_d = hist_q;
    if (clear) begin
      hist_d = '0;
    end else if (shift_en) begin
      hist_d = {hist_q[ORDER-2:0], shift_bit};
    end
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      hist_q <= '0;
    end else begin
      hist_q <= hist_d;
    end
  end

  // hist_q[k-1] holds the bit received k steps ago
  assign pred = hist_q[TAP_A-1] ^ hist_q[TAP_B-1];
endmodule

// File: rtl/err_window_judge.sv
// Tallies main and slip errors over fixed windows and decides on resync.
module err_window_judge #(
  parameter int unsigned WIN_LEN = 256,
  parameter int unsigned ERR_HI  = 64,
  parameter int unsigned SLIP_LO = 8
) (
  input  logic clk,
  input  logic rst_n,
  input  logic step,
  input  logic clear,
  input  logic bit_err,
  input  logic slip_err,
  output logic trip
);
  localparam int unsigned POS_W = (WIN_LEN > 1) ? $clog2(WIN_LEN) : 1;
  localparam int unsigned TAL_W = $clog2(WIN_LEN + 1);

  logic [POS_W-1:0] pos_q, pos_d;
  logic [TAL_W-1:0] err_tally_q, err_tally_d;
  logic [TAL_W-1:0] slip_tally_q, slip_tally_d;
  logic [TAL_W-1:0] err_sum, slip_sum;
  logic             last_bit;

  always_comb begin
    err_sum  = err_tally_q + TAL_W'(bit_err);
    slip_sum = slip_tally_q + TAL_W'(slip_err);
    last_bit = (pos_q == POS_W'(WIN_LEN - 1));
    trip     = step && last_bit &&
               (err_sum >= TAL_W'(ERR_HI)) &&
               (slip_sum <= TAL_W'(SLIP_LO));
  end

  always_comb begin
    pos_d        = pos_q;
    err_tally_d  = err_tally_q;
    slip_tally_d = slip_tally_q;
    if (clear) begin
      pos_d        = '0;
      err_tally_d  = '0;
      slip_tally_d = '0;
    end else if (step) begin
      if (last_bit) begin
        pos_d        = '0;
        err_tally_d  = '0;
        slip_tally_d = '0;
      end else begin
        pos_d        = pos_q + 1'b1;
        err_tally_d  = err_sum;
        slip_tally_d = slip_sum;
      end
    end
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      pos_q        <= '0;
      err_tally_q  <= '0;
      slip_tally_q <= '0;
    end else begin
      pos_q        <= pos_d;
      err_tally_q  <= err_tally_d;
      slip_tally_q <= slip_tally_d;
    end
  end
endmodule

// File: rtl/sat_event_counter.sv
// Event counter that stops at its all-ones value.
module sat_event_counter #(
  parameter int unsigned W = 32
) (
  input  logic         clk,
  input  logic         rst_n,
  input  logic         inc,
  output logic [W-1:0] count
);
  logic [W-1:0] count_q, count_d;

  always_comb begin
    count_d = count_q;
    if (inc && !(&count_q)) begin
      count_d = count_q + 1'b1;
    end
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      count_q <= '0;
    end else begin
      count_q <= count_d;
    end
  end

  assign count = count_q;
endmodule

// File: rtl/prbs_slip_checker.sv
module prbs_slip_checker #(
  parameter int unsigned ORDER   = 23,
  parameter int unsigned TAP_A   = 23,
  parameter int unsigned TAP_B   = 18,
  parameter int unsigned WIN_LEN = 256,
  parameter int unsigned ERR_HI  = 64,
  parameter int unsigned SLIP_LO = 8,
  parameter int unsigned CNT_W   = 32
) (
  input  logic             clk,
  input  logic             rst_n,
  input  logic             rx_bit,
  input  logic             rx_valid,
  output logic             err_flag,
  output logic             resync_req,
  output logic [CNT_W-1:0] err_count
);
  import prbs_chk_pkg::*;

  localparam int unsigned FILL_W = $clog2(ORDER);

  sync_state_e       state_q, state_d;
  logic [FILL_W-1:0] fill_q, fill_d;
  logic              err_flag_q, resync_q;

  logic loading, step;
  logic main_pred, main_shift_bit;
  logic slip_pred, bit_err, slip_err;
  logic trip;

  assign loading        = (state_q == ST_LOAD);
  assign step           = rx_valid && !loading;
  // Loading takes the line; tracking free-runs on the local prediction
  assign main_shift_bit = loading ? rx_bit : main_pred;
  assign bit_err        = step && (rx_bit ^ main_pred);
  assign slip_err       = step && (bit_err ^ slip_pred);

  prbs_tap_predictor #(
    .ORDER (ORDER),
    .TAP_A (TAP_A),
    .TAP_B (TAP_B)
  ) u_main_pred (
    .clk       (clk),
    .rst_n     (rst_n),
    .shift_en  (rx_valid),
    .clear     (1'b0),
    .shift_bit (main_shift_bit),
    .pred      (main_pred)
  );

  // Second stage: the same recurrence applied to the error stream
  prbs_tap_predictor #(
    .ORDER (ORDER),
    .TAP_A (TAP_A),
    .TAP_B (TAP_B)
  ) u_slip_pred (
    .clk       (clk),
    .rst_n     (rst_n),
    .shift_en  (step),
    .clear     (loading),
    .shift_bit (bit_err),
    .pred      (slip_pred)
  );

  err_window_judge #(
    .WIN_LEN (WIN_LEN),
    .ERR_HI  (ERR_HI),
    .SLIP_LO (SLIP_LO)
  ) u_judge (
    .clk      (clk),
    .rst_n    (rst_n),
    .step     (step),
    .clear    (loading),
    .bit_err  (bit_err),
    .slip_err (slip_err),
    .trip     (trip)
  );

  sat_event_counter #(
    .W (CNT_W)
  ) u_count (
    .clk   (clk),
    .rst_n (rst_n),
    .inc   (bit_err),
    .count (err_count)
  );

  always_comb begin
    state_d = state_q;
    fill_d  = fill_q;
    unique case (state_q)
      ST_LOAD: begin
        if (rx_valid) begin
          if (fill_q == FILL_W'(ORDER - 1)) begin
            state_d = ST_TRACK;
            fill_d  = '0;
          end else begin
            fill_d = fill_q + 1'b1;
          end
        end
      end
      ST_TRACK: begin
        if (trip) begin
          state_d = ST_LOAD;
          fill_d  = '0;
        end
      end
      default: begin
        state_d = ST_LOAD;
        fill_d  = '0;
      end
    endcase
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      state_q    <= ST_LOAD;
      fill_q     <= '0;
      err_flag_q <= 1'b0;
      resync_q   <= 1'b0;
    end else begin
      state_q    <= state_d;
      fill_q     <= fill_d;
      err_flag_q <= bit_err;
      resync_q   <= trip;
    end
  end

  assign err_flag   = err_flag_q;
  assign resync_req = resync_q;
endmodule

// File: rtl/prbs_slip_checker_sva.sv
module prbs_slip_checker_sva #(
  parameter int unsigned CNT_W = 32
) (
  input logic             clk,
  input logic             rst_n,
  input logic             rx_valid,
  input logic             err_flag,
  input logic             resync_req,
  input logic [CNT_W-1:0] err_count
);
  localparam logic [CNT_W-1:0] CNT_MAX = '1;

  AST_RESYNC_PULSE: assert property (@(posedge clk) disable iff (!rst_n)
    resync_req |=> !resync_req); // R7

  AST_RELOAD_QUIET: assert property (@(posedge clk) disable iff (!rst_n)
    resync_req |=> !err_flag); // R2

  AST_FLAG_NEEDS_VALID: assert property (@(posedge clk) disable iff (!rst_n)
    err_flag |-> $past(rx_valid)); // R5

  AST_COUNT_STEP: assert property (@(posedge clk) disable iff (!rst_n)
    (err_flag && ($past(err_count) != CNT_MAX)) |->
      (err_count == CNT_W'($past(err_count) + 1'b1))); // R10

  AST_COUNT_HOLD: assert property (@(posedge clk) disable iff (!rst_n)
    !err_flag |-> $stable(err_count)); // R10

  AST_COUNT_SAT: assert property (@(posedge clk) disable iff (!rst_n)
    (err_count == CNT_MAX) |=> (err_count == CNT_MAX)); // R10
endmodule

bind prbs_slip_checker prbs_slip_checker_sva #(.CNT_W(CNT_W)) u_sva (
  .clk        (clk),
  .rst_n      (rst_n),
  .rx_valid   (rx_valid),
  .err_flag   (err_flag),
  .resync_req (resync_req),
  .err_count  (err_count)
);

// File: tb/tb_prbs_slip_checker.sv
`timescale 1ns/1ps
module tb_prbs_slip_checker;
  localparam int unsigned CNT_W = 8;

  logic             clk = 1'b0;
  logic             rst_n;
  logic             rx_bit;
  logic             rx_valid;
  logic             err_flag;
  logic             resync_req;
  logic [CNT_W-1:0] err_count;

  always #4 clk = ~clk; // 125 MHz

  prbs_slip_checker #(.CNT_W(CNT_W)) dut (
    .clk        (clk),
    .rst_n      (rst_n),
    .rx_bit     (rx_bit),
    .rx_valid   (rx_valid),
    .err_flag   (err_flag),
    .resync_req (resync_req),
    .err_count  (err_count)
  );

  // Segment vectors: {mode[1:0], length[15:0], expected count[15:0]}
  // mode 0 clean, 1 one flipped bit every 40, 2 every bit inverted
  localparam logic [33:0] VEC [0:3] = '{
    {2'd0, 16'd600, 16'd0},
    {2'd1, 16'd200, 16'd5},
    {2'd2, 16'd100, 16'd100},
    {2'd2, 16'd300, 16'd255}
  };

  int          n_cmp = 0;
  int          n_bad = 0;
  bit          done  = 1'b0;
  logic [22:0] g;

  task automatic chk(input bit ok, input string tag, input longint act, input longint exp);
    n_cmp++;
    if (!ok) begin
      n_bad++;
      $display("FAIL %s: actual %0d expected %0d", tag, act, exp);
    end
  endtask

  // Reference sequence: x[n] = x[n-23] ^ x[n-18], g[0] newest
  task automatic next_bit(output logic b);
    b = g[22] ^ g[17];
    g = {g[21:0], b};
  endtask

  task automatic send(input logic b, output logic fl, output logic rs);
    rx_bit   = b;
    rx_valid = 1'b1;
    @(negedge clk);
    fl = err_flag;
    rs = resync_req;
  endtask

  task automatic do_reset();
    rx_valid = 1'b0;
    rx_bit   = 1'b0;
    rst_n    = 1'b0;
    repeat (3) @(negedge clk);
    chk(err_flag == 1'b0 && resync_req == 1'b0 && err_count == '0,
        "R1 reset outputs", {err_flag, resync_req, err_count}, 0);
    rst_n = 1'b1;
    @(negedge clk);
    chk(err_flag == 1'b0 && resync_req == 1'b0 && err_count == '0,
        "R1 after release", {err_flag, resync_req, err_count}, 0);
  endtask

  task automatic sync_up(input logic [22:0] seed);
    int   bad;
    logic fl, rs;
    bad = 0;
    g   = seed;
    for (int i = 22; i >= 0; i--) begin
      send(seed[i], fl, rs);
      if (fl || rs) bad++;
    end
    chk(bad == 0 && err_count == '0, "R2 load quiet", bad, 0);
  endtask

  initial begin
    repeat (200000) @(posedge clk);
    if (!done) begin
      n_bad++;
      $display("FAIL watchdog: actual timeout expected completion");
      $display("*** SUMMARY: %0d compared / %0d mismatched ***", n_cmp, n_bad);
      $finish;
    end
  end

  initial begin
    logic        b, fl, rs, flip;
    int          flagbad, rs_seen;
    string       tag;
    logic [CNT_W-1:0] snap;

    // Table walk: each segment after a fresh reset and load
    for (int e = 0; e < 4; e++) begin
      logic [1:0]  mode;
      logic [15:0] len, expc;
      mode = VEC[e][33:32];
      len  = VEC[e][31:16];
      expc = VEC[e][15:0];
      case (mode)
        2'd0:    tag = "R4 clean";
        2'd1:    tag = "R3 isolated errors";
        default: tag = (len > 16'd255) ? "R10 saturation" : "R8 burst";
      endcase
      do_reset();
      sync_up(23'h1ACE5 + 23'(e * 977));
      flagbad = 0;
      rs_seen = 0;
      for (int i = 0; i < int'(len); i++) begin
        next_bit(b);
        flip = (mode == 2'd2) || (mode == 2'd1 && (i % 40) == 0);
        send(b ^ flip, fl, rs);
        if (fl !== flip) flagbad++;
        if (rs) rs_seen++;
      end
      for (int i = 0; i < 300; i++) begin
        next_bit(b);
        send(b, fl, rs);
        if (fl) flagbad++;
        if (rs) rs_seen++;
      end
      chk(flagbad == 0, {tag, " flag pattern"}, flagbad, 0);
      chk(err_count == CNT_W'(expc), {tag, " count"}, err_count, expc);
      chk(rs_seen == 0, {tag, " no resync (R8)"}, rs_seen, 0);
    end

    // R5: invalid cycles carrying wrong data are ignored
    do_reset();
    sync_up(23'h7FFFFF);
    flagbad = 0;
    for (int i = 0; i < 200; i++) begin
      next_bit(b);
      rx_bit   = ~b;
      rx_valid = 1'b0;
      @(negedge clk);
      if (err_flag || resync_req) flagbad++;
      send(b, fl, rs);
      if (fl || rs) flagbad++;
    end
    chk(flagbad == 0, "R5 gaps ignored", flagbad, 0);
    chk(err_count == '0, "R5 count untouched", err_count, 0);

    // R6/R9/R7: one deleted bit leads to a resync on a window boundary
    do_reset();
    sync_up(23'h2B3C4D);
    begin
      int  tcount, rs_at;
      tcount = 0;
      rs_at  = -1;
      for (int i = 0; i < 300; i++) begin
        next_bit(b);
        send(b, fl, rs);
        tcount++;
      end
      next_bit(b); // deleted bit
      for (int i = 0; i < 2000 && rs_at < 0; i++) begin
        next_bit(b);
        send(b, fl, rs);
        tcount++;
        if (rs) rs_at = tcount;
      end
      chk(rs_at > 0, "R9 R6 slip gives resync", rs_at, 1);
      chk(rs_at > 0 && (rs_at % 256) == 0, "R7 window boundary", rs_at % 256, 0);
    end
    snap    = err_count;
    flagbad = 0;
    rs_seen = 0;
    for (int i = 0; i < 23; i++) begin
      next_bit(b);
      send(~b, fl, rs); // any content loads without being counted
      g = {g[22:1], ~b};
      if (fl || rs) flagbad++;
    end
    chk(flagbad == 0 && err_count == snap, "R2 R10 reload not counted", err_count, snap);
    for (int i = 0; i < 400; i++) begin
      next_bit(b);
      send(b, fl, rs);
      if (fl) flagbad++;
      if (rs) rs_seen++;
    end
    chk(flagbad == 0 && rs_seen == 0, "R9 clean after reacquire", flagbad + rs_seen, 0);
    chk(err_count == snap, "R10 count stable after reacquire", err_count, snap);

    done = 1'b1;
    $display("*** SUMMARY: %0d compared / %0d mismatched ***", n_cmp, n_bad);
    $finish;
  end
endmodule